// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is the station side of a two-wire management bus that reaches PHY devices. It takes one command at a time: a read/write flag, a 5-bit PHY address, a 5-bit register address and 16 bits of write data, presented with a single-cycle start strobe. From this it builds a 64-bit management frame and shifts it out serially on the data line. The clock line is a divided copy of the system clock.

On write frames the station drives every bit, including both turnaround bits. On read frames the station stops driving at the first turnaround bit. It then samples the turnaround zero and the 16 data bits that the addressed PHY returns. When a frame and one trailing idle clock period are over, the block pulses `done`. For reads it also presents the captured word, and it sets a no-response flag if the PHY did not pull the second turnaround bit low. The data line is split into output, output enable and input, so that the pad tristate sits outside the block.

Top module: `mdio_master`

## Requirements
- R1: `mdc` is low out of reset and toggles every `HALF_DIV` system clocks, so its period is 2*`HALF_DIV` system clocks. The default of 20 gives 2.5 MHz from 100 MHz.
- R2: A frame opens with 32 bit periods in which the station drives `mdio_o` high.
- R3: The start field (0, then 1) follows the preamble. Then comes the opcode, sent as 0,1 for a write (`cmd_read`=0) and as 1,0 for a read (`cmd_read`=1).
- R4: After the opcode the PHY address is sent bit 4 first, then the register address, bit 4 first (frame bit periods 36..45).
- R5: On a write the station drives turnaround as 1 then 0 (periods 46, 47), then the write data, bit 15 first (periods 48..63).
- R6: On a read `mdio_oe` goes low at the start of bit period 46 and stays low through period 63.
- R7: On a read, `mdio_i` is sampled at the rising `mdc` edge of periods 48..63, bit 15 first. The word appears on `rd_data` in the cycle in which `done` is high.
- R8: `no_resp` is updated together with `done`. It is 1 only when the frame was a read and the sample of period 47 was 1. A write clears it.
- R9: `mdio_oe` is low while idle and during period 64, which is one idle `mdc` period after the last bit. `done` pulses for one system clock at the falling `mdc` edge that ends period 64, and `busy` clears in that same cycle.
- R10: A `cmd_start` seen while `busy` is high is ignored: the frame in progress is unchanged and no frame follows it.
- R11: `mdio_o` and `mdio_oe` change only in cycles where `mdc` falls. The first bit goes out at the first falling edge after the accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | One-cycle command strobe, accepted when not busy |
| cmd_read | input | 1 | 1 = read frame, 0 = write frame |
| cmd_phy | input | 5 | PHY address |
| cmd_reg | input | 5 | Register address |
| cmd_wdata | input | 16 | Write data |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rd_data | output | 16 | Word captured by the last read |
| no_resp | output | 1 | Last read saw no turnaround zero |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line drive enable |
| mdio_i | input | 1 | Data line input value |

## Verification
The embedded assertions check, on every cycle, the following properties. `mdc` moves only on divider terminal counts. The line changes only on falling `mdc` edges. The line is driven only while busy and is never driven while a read sample is taken. `done` lasts one cycle, and a write never leaves `no_resp` set. The actual field contents, bit order, release position, captured data and the ignored-start behaviour can only be shown by the bench scenarios. There, a cycle-level reference model and a behavioural PHY that answers reads with chosen words and good or missing turnaround zeros are compared against the outputs.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int POS_W      = $clog2(FRAME_BITS + 1);
  localparam int TA_FIRST   = 46;
  localparam int TA_SECOND  = 47;
  localparam int DATA_FIRST = 48;

  // Frame image, element 63 leaves the wire first.
  function automatic logic [FRAME_BITS-1:0] build_frame(
    input logic        rd,
    input logic [4:0]  phy,
    input logic [4:0]  regad,
    input logic [15:0] wd
  );
    logic [1:0] op;
    logic [1:0] ta;
    op = rd ? 2'b10 : 2'b01;
    ta = rd ? 2'b00 : 2'b10;
    return {32'hFFFF_FFFF, 2'b01, op, phy, regad, ta, (rd ? 16'h0000 : wd)};
  endfunction

  function automatic logic drive_en(input logic rd, input logic [POS_W-1:0] pos);
    return (pos < POS_W'(FRAME_BITS)) && !(rd && pos >= POS_W'(TA_FIRST));
  endfunction

  function automatic logic bit_at(input logic [FRAME_BITS-1:0] f,
                                  input logic [POS_W-1:0] pos);
    logic [POS_W-1:0] idx;
    idx = POS_W'(FRAME_BITS - 1) - pos;
    return f[idx[5:0]];
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int HALF_DIV = 20
) (
  input  logic clk,
  input  logic rst_n,
  output logic mdc,
  output logic fall_tick,
  output logic rise_tick
);
  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CNT_W-1:0] cnt;
  logic             tick;

  assign tick      = (cnt == CNT_W'(HALF_DIV - 1));
  assign fall_tick = tick && mdc;
  assign rise_tick = tick && !mdc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= !mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_MDC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(mdc)); // R1
  AST_MDC_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (mdc != $past(mdc))); // R1
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_start,
  input  logic        cmd_read,
  input  logic [4:0]  cmd_phy,
  input  logic [4:0]  cmd_reg,
  input  logic [15:0] cmd_wdata,
  input  logic        fall_tick,
  input  logic        rise_tick,
  output logic        busy,
  output logic        done,
  output logic        finish,
  output logic        sample_ta,
  output logic        sample_data,
  output logic        read_q,
  output logic        mdio_o,
  output logic        mdio_oe
);
  logic [FRAME_BITS-1:0] frame_q;
  logic [POS_W-1:0]      pos;
  logic                  active;
  logic                  accept;

  assign accept      = cmd_start && !busy;
  assign finish      = fall_tick && busy && active && (pos == POS_W'(FRAME_BITS));
  assign mdio_oe     = active && drive_en(read_q, pos);
  assign mdio_o      = mdio_oe ? bit_at(frame_q, pos) : 1'b1;
  assign sample_ta   = rise_tick && active && read_q && (pos == POS_W'(TA_SECOND));
  assign sample_data = rise_tick && active && read_q &&
                       (pos >= POS_W'(DATA_FIRST)) && (pos < POS_W'(FRAME_BITS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      active  <= 1'b0;
      pos     <= '0;
      read_q  <= 1'b0;
      frame_q <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy    <= 1'b1;
        active  <= 1'b0;
        pos     <= '0;
        read_q  <= cmd_read;
        frame_q <= build_frame(cmd_read, cmd_phy, cmd_reg, cmd_wdata);
      end else if (fall_tick && busy) begin
        if (!active) begin
          active <= 1'b1;
          pos    <= '0;
        end else if (finish) begin
          done   <= 1'b1;
          busy   <= 1'b0;
          active <= 1'b0;
        end else begin
          pos <= pos + 1'b1;
        end
      end
    end
  end

  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_tick |=> ($stable(mdio_oe) && $stable(mdio_o))); // R11
  AST_IGNORE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_start) |=> ($stable(frame_q) && $stable(read_q))); // R10
endmodule

// File: rtl/mdio_rx_capture.sv
module mdio_rx_capture (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mdio_i,
  input  logic        sample_ta,
  input  logic        sample_data,
  input  logic        finish,
  input  logic        read_q,
  output logic [15:0] rd_data,
  output logic        no_resp
);
  logic [15:0] shreg;
  logic        ta_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg   <= '0;
      ta_seen <= 1'b0;
      rd_data <= '0;
      no_resp <= 1'b0;
    end else begin
      if (sample_ta)   ta_seen <= mdio_i;
      if (sample_data) shreg   <= {shreg[14:0], mdio_i};
      if (finish) begin
        no_resp <= read_q && ta_seen;
        if (read_q) rd_data <= shreg;
      end
    end
  end

  AST_WRITE_CLEARS_NORESP: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && !read_q) |=> !no_resp); // R8
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int HALF_DIV = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_start,
  input  logic        cmd_read,
  input  logic [4:0]  cmd_phy,
  input  logic [4:0]  cmd_reg,
  input  logic [15:0] cmd_wdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] rd_data,
  output logic        no_resp,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic fall_tick, rise_tick;
  logic finish, sample_ta, sample_data, read_q;

  mdio_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk(clk), .rst_n(rst_n), .mdc(mdc),
    .fall_tick(fall_tick), .rise_tick(rise_tick)
  );

  mdio_frame_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_start(cmd_start), .cmd_read(cmd_read), .cmd_phy(cmd_phy),
    .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata),
    .fall_tick(fall_tick), .rise_tick(rise_tick),
    .busy(busy), .done(done), .finish(finish),
    .sample_ta(sample_ta), .sample_data(sample_data), .read_q(read_q),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  mdio_rx_capture u_cap (
    .clk(clk), .rst_n(rst_n), .mdio_i(mdio_i),
    .sample_ta(sample_ta), .sample_data(sample_data),
    .finish(finish), .read_q(read_q),
    .rd_data(rd_data), .no_resp(no_resp)
  );

  AST_SAMPLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_ta || sample_data) |-> !mdio_oe); // R6
  AST_OE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> busy); // R9
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !mdio_oe)); // R9
endmodule

// File: tb/mdio_master_test.sv
module mdio_master_test;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_start = 1'b0, cmd_read = 1'b0;
  logic [4:0] cmd_phy = '0, cmd_reg = '0;
  logic [15:0] cmd_wdata = '0;
  logic busy, done, no_resp, mdc, mdio_o, mdio_oe;
  logic [15:0] rd_data;
  logic mdio_i = 1'b1;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  mdio_master #(.HALF_DIV(HALF)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_read(cmd_read),
    .cmd_phy(cmd_phy), .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata),
    .busy(busy), .done(done), .rd_data(rd_data), .no_resp(no_resp),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at t=%0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int  m_cnt, m_pos;
  bit  m_mdc, m_busy, m_act, m_done, m_isrd, m_ta, m_noresp;
  bit  m_bit[64];
  bit  m_oe[64];
  logic [15:0] m_sh, m_rdata;

  function automatic string field_req(int p, bit rd);
    if (p < 32) return "R2";
    if (p < 36) return "R3";
    if (p < 46) return "R4";
    if (p < 64) return rd ? "R6" : "R5";
    return "R9";
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_mdc = 0; m_busy = 0; m_act = 0; m_pos = 0; m_done = 0;
      m_isrd = 0; m_ta = 0; m_noresp = 0; m_sh = '0; m_rdata = '0;
    end else begin
      bit tick;
      tick = (m_cnt == HALF - 1);
      m_done = 0;
      if (cmd_start && !m_busy) begin
        m_busy = 1; m_act = 0; m_pos = 0; m_isrd = cmd_read;
        for (int i = 0; i < 32; i++) m_bit[i] = 1;
        m_bit[32] = 0; m_bit[33] = 1;
        m_bit[34] = cmd_read; m_bit[35] = !cmd_read;
        for (int k = 0; k < 5; k++) begin
          m_bit[36+k] = cmd_phy[4-k];
          m_bit[41+k] = cmd_reg[4-k];
        end
        m_bit[46] = !cmd_read; m_bit[47] = 0;
        for (int k = 0; k < 16; k++) m_bit[48+k] = cmd_read ? 1'b0 : cmd_wdata[15-k];
        for (int i = 0; i < 64; i++) m_oe[i] = !(cmd_read && i >= 46);
      end else if (tick && m_mdc && m_busy) begin
        if (!m_act) begin
          m_act = 1; m_pos = 0;
        end else if (m_pos == 64) begin
          m_done = 1; m_busy = 0; m_act = 0;
          if (m_isrd) begin m_rdata = m_sh; m_noresp = m_ta; end
          else m_noresp = 0;
        end else m_pos++;
      end
      if (tick && !m_mdc && m_act && m_isrd) begin
        if (m_pos == 47) m_ta = mdio_i;
        else if (m_pos >= 48 && m_pos <= 63) m_sh = {m_sh[14:0], mdio_i};
      end
      if (tick) begin m_cnt = 0; m_mdc = !m_mdc; end
      else m_cnt++;
    end
  end

  // per-cycle comparison away from the active edge
  bit prev_oe, prev_o;
  always @(negedge clk) begin
    if (rst_n) begin
      bit eoe, eo;
      eoe = m_act && m_pos < 64 && m_oe[m_pos];
      eo  = eoe ? m_bit[m_pos] : 1'b1;
      check("R1", "mdc", mdc, m_mdc);
      check(field_req(m_act ? m_pos : 64, m_isrd), "mdio_oe", mdio_oe, eoe);
      if (eoe) check(field_req(m_pos, m_isrd), "mdio_o", mdio_o, eo);
      check("R9", "busy", busy, m_busy);
      check("R9", "done", done, m_done);
      if (m_done) begin
        check("R7", "rd_data at done", rd_data, m_rdata);
        check("R8", "no_resp at done", no_resp, m_noresp);
      end
    end
  end

  // ---------------- PHY model ----------------
  bit phy_armed = 0;
  bit phy_ta_bad = 0;
  logic [15:0] phy_word = '0;
  int phase = 0;
  bit pm_mdc = 0, pm_oe = 0;
  always @(negedge clk) begin
    if (pm_mdc && !mdc && phase > 0) begin
      phase++;
      if (phase == 2) mdio_i = phy_ta_bad;
      else if (phase >= 3 && phase <= 18) mdio_i = phy_word[18-phase];
      else begin mdio_i = 1'b1; phase = 0; end
    end
    if (pm_oe && !mdio_oe && busy && phy_armed) begin
      phase = 1; phy_armed = 0;
    end
    pm_mdc = mdc; pm_oe = mdio_oe;
  end

  // ---------------- stimulus ----------------
  task automatic issue(input bit rd, input logic [4:0] p, input logic [4:0] r,
                       input logic [15:0] d);
    @(negedge clk);
    cmd_read = rd; cmd_phy = p; cmd_reg = r; cmd_wdata = d; cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic do_read(input logic [4:0] p, input logic [4:0] r,
                         input logic [15:0] w, input bit bad);
    phy_word = w; phy_ta_bad = bad; phy_armed = 1;
    issue(1'b1, p, r, 16'h0);
    wait_done();
    check("R7", "read word", rd_data, bad ? rd_data : w);
    check("R8", "no response flag", no_resp, bad);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset mdc", mdc, 0);
    check("R9", "reset oe", mdio_oe, 0);
    check("R9", "reset busy", busy, 0);
    check("R9", "reset done", done, 0);
    rst_n = 1'b1;

    issue(1'b0, 5'h01, 5'h00, 16'hA5C3);
    wait_done();
    check("R8", "write leaves no_resp low", no_resp, 0);
    do_read(5'h1F, 5'h1F, 16'h8001, 1'b0);
    do_read(5'h0A, 5'h15, 16'h1234, 1'b1);
    check("R8", "write clears no_resp (before)", no_resp, 1);
    issue(1'b0, 5'h00, 5'h00, 16'h0000);
    wait_done();
    check("R8", "write clears no_resp", no_resp, 0);
    do_read(5'h15, 5'h0A, 16'hFFFF, 1'b0);

    // R10: a start during a frame is dropped
    phy_word = 16'h5A0F; phy_ta_bad = 0; phy_armed = 1;
    issue(1'b1, 5'h03, 5'h11, 16'h0);
    repeat (200) @(negedge clk);
    issue(1'b0, 5'h1C, 5'h02, 16'hDEAD);
    check("R10", "busy held after ignored start", busy, 1);
    wait_done();
    check("R10", "first command result kept", rd_data, 16'h5A0F);
    repeat (4 * HALF * 3) @(negedge clk);
    check("R10", "no queued frame", busy, 0);
    check("R11", "line idle after ignored start", mdio_oe, 0);

    do_read(5'h12, 5'h07, 16'h0001, 1'b0);
    repeat (10) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule